// File: doc/BRIEF.md
# Multi-Port Serial Management Slave

This block is the management-bus slave for a device with eight PHY ports, each with its own bank of 16-bit registers. It runs on the management clock and samples the bidirectional data line on every rising edge. It tracks each frame from the idle preamble through the start bits, opcode, PHY address, register address, turnaround and the 16-bit data field. When the PHY address selects one of its ports, a write frame updates that port's register and a read frame returns that register's value on the data line through a tri-state enable.

The addresses come from a 5-bit strap value taken as a base. Port `k` answers at `(base + k) mod 32`, so the eight ports take eight consecutive addresses and wrap past 31. A reduced strap mode keeps only the top two strap bits, which gives bases of 0, 8, 16 or 24. A disable input keeps the slave off the bus completely. The line is bit-serial and has no handshake or back-pressure: one bit moves per clock, in both directions.

Top module: `mdio_mport_slave`

## Requirements
- R1: A frame is recognised only after at least 32 consecutive ones sampled on `mdio_in`, followed by the start bits 0 then 1. A shorter run of ones or a wrong start pattern is ignored and changes no register.
- R2: The two opcode bits (first bit sent first) are 1,0 for a read and 0,1 for a write. A frame with opcode 0,0 or 1,1 is dropped: no drive and no register change.
- R3: After the opcode come the 5-bit PHY address and then the 5-bit register address, both MSB first. Port k answers when the PHY address equals (base + k) modulo 32, for k in 0..7.
- R4: With `strap_reduced` high, the base is {`strap_base[4:3]`, 3'b000}, so only the top two strap bits choose among 0, 8, 16 and 24.
- R5: In a matched read, the slave leaves the line undriven during the first turnaround bit and drives 0 during the second.
- R6: Read data is driven from bit 15 down to bit 0. Each bit is updated just after a rising edge, ready for the master to sample at the next one. The enable drops right after bit 0.
- R7: A matched write stores the 16 data bits (MSB first) into the addressed register of the addressed port, only once all 16 bits have arrived. A later read returns that value.
- R8: A frame whose PHY address selects no port is followed to its end, but it never drives the line and never changes a register.
- R9: While `mgmt_off` is high, `mdio_oe` stays low and every frame is ignored.
- R10: Reset clears every register of every port to zero and leaves `mdio_oe` low.
- R11: A write to one port leaves the same register address in every other port unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; all sampling and updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mgmt_off | input | 1 | High: slave silent and all frames ignored |
| strap_base | input | 5 | Strapped base PHY address |
| strap_reduced | input | 1 | High: base uses only strap bits 4:3, low bits forced to zero |
| mdio_in | input | 1 | Sampled value of the data line |
| mdio_out | output | 1 | Value driven onto the data line when enabled |
| mdio_oe | output | 1 | Tri-state enable for the data line |

## Verification
The bench goes after preamble counting at its edge: a run of 31 ones must be rejected and exactly 32 accepted. A counter that is off by one would take a write that should be dropped, or miss one that should land. It sends frames with bad start bits and illegal opcodes; a decoder that does not return to preamble search would corrupt a register, which a later read shows. Address matching is tested just below the base, just above the top port, at the 31-to-0 wrap and in the reduced strap mode, where a wrong subtraction would answer the wrong address or write the wrong port. The read turnaround and data are sampled slot by slot, so a drive one cycle early or late, or an enable held past bit 0, shows up as a shape or data mismatch.

// File: rtl/mdio_mport_pkg.sv
`timescale 1ns/1ps
package mdio_mport_pkg;

  // Decoder position within a management frame
  typedef enum logic [2:0] {
    S_PRE  = 3'd0,  // counting ones
    S_ST1  = 3'd1,  // expecting second start bit (1)
    S_OP   = 3'd2,  // two opcode bits
    S_PHY  = 3'd3,  // PHY address bits
    S_REG  = 3'd4,  // register address bits
    S_TA1  = 3'd5,  // first turnaround bit
    S_TA2  = 3'd6,  // second turnaround bit
    S_DATA = 3'd7   // sixteen data bits
  } frame_state_t;

  localparam logic [1:0] OPC_RD = 2'b10;
  localparam logic [1:0] OPC_WR = 2'b01;

endpackage

// File: rtl/mdio_port_match.sv
`timescale 1ns/1ps
module mdio_port_match #(
  parameter int NUM_PORTS = 8,
  parameter int ADDR_W    = 5,
  parameter int KEEP_BITS = 2,
  localparam int PIW      = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic [ADDR_W-1:0] strap_base,
  input  logic              strap_reduced,
  output logic              port_hit,
  output logic [PIW-1:0]    port_idx
);

  logic [ADDR_W-1:0] base_eff;
  logic [ADDR_W-1:0] offset;

  // Reduced mode keeps only the top strap bits; the rest read as zero.
  always_comb begin
    if (strap_reduced)
      base_eff = {strap_base[ADDR_W-1 -: KEEP_BITS], {(ADDR_W-KEEP_BITS){1'b0}}};
    else
      base_eff = strap_base;
  end

  // Modular distance from the base selects the port.
  assign offset   = phy_addr - base_eff;
  assign port_hit = ({1'b0, offset} < (ADDR_W+1)'(NUM_PORTS));
  assign port_idx = offset[PIW-1:0];

endmodule

// File: rtl/mdio_reg_bank.sv
`timescale 1ns/1ps
module mdio_reg_bank #(
  parameter int NUM_PORTS = 8,
  parameter int NUM_REGS  = 32,
  parameter int DATA_W    = 16,
  localparam int PIW      = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int REG_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              mdc,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PIW-1:0]    wr_port,
  input  logic [REG_W-1:0]  wr_reg,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PIW-1:0]    rd_port,
  input  logic [REG_W-1:0]  rd_reg,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] port_word [NUM_PORTS];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [DATA_W-1:0] regs [NUM_REGS];
    logic              sel;

    assign sel = wr_en && (wr_port == PIW'(p));

    always_ff @(posedge mdc or negedge rst_n) begin
      if (!rst_n) begin
        for (int r = 0; r < NUM_REGS; r++) regs[r] <= '0;
      end else if (sel) begin
        regs[wr_reg] <= wr_data;
      end
    end

    assign port_word[p] = regs[rd_reg];
  end

  assign rd_data = port_word[rd_port];

endmodule

// File: rtl/mdio_frame_dec.sv
`timescale 1ns/1ps
module mdio_frame_dec
  import mdio_mport_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int ADDR_W  = 5,
  parameter int REG_W   = 5,
  parameter int DATA_W  = 16,
  localparam int PCW    = $clog2(PRE_LEN + 1),
  localparam int BCW    = $clog2(DATA_W)
) (
  input  logic              mdc,
  input  logic              rst_n,
  input  logic              mgmt_off,
  input  logic              mdio_in,
  input  logic              port_hit,
  input  logic [DATA_W-1:0] rd_word,
  output logic [ADDR_W-1:0] phy_addr,
  output logic [REG_W-1:0]  reg_addr,
  output logic              frame_rd,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              drv_oe,
  output logic              drv_out
);

  frame_state_t      state;
  logic [PCW-1:0]    pre_cnt;
  logic [BCW-1:0]    bit_cnt;
  logic [1:0]        op_q;
  logic [DATA_W-1:0] rd_sh;
  logic [DATA_W-1:0] wd_sh;
  logic [DATA_W-1:0] wd_next;
  logic [1:0]        op_next;

  assign wd_next = {wd_sh[DATA_W-2:0], mdio_in};
  assign op_next = {op_q[0], mdio_in};

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_PRE;
      pre_cnt  <= '0;
      bit_cnt  <= '0;
      op_q     <= '0;
      phy_addr <= '0;
      reg_addr <= '0;
      frame_rd <= 1'b0;
      wr_en    <= 1'b0;
      wr_data  <= '0;
      rd_sh    <= '0;
      wd_sh    <= '0;
      drv_oe   <= 1'b0;
      drv_out  <= 1'b0;
    end else if (mgmt_off) begin
      state   <= S_PRE;
      pre_cnt <= '0;
      wr_en   <= 1'b0;
      drv_oe  <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      unique case (state)
        S_PRE: begin
          if (mdio_in) begin
            if (pre_cnt != PCW'(PRE_LEN)) pre_cnt <= pre_cnt + 1'b1;
          end else begin
            if (pre_cnt == PCW'(PRE_LEN)) state <= S_ST1;
            pre_cnt <= '0;
          end
        end
        S_ST1: begin
          if (mdio_in) begin
            state   <= S_OP;
            bit_cnt <= BCW'(1);
          end else begin
            state <= S_PRE;
          end
        end
        S_OP: begin
          op_q <= op_next;
          if (bit_cnt == '0) begin
            bit_cnt <= BCW'(ADDR_W - 1);
            if (op_next == OPC_RD) begin
              frame_rd <= 1'b1;
              state    <= S_PHY;
            end else if (op_next == OPC_WR) begin
              frame_rd <= 1'b0;
              state    <= S_PHY;
            end else begin
              state <= S_PRE;
            end
          end else begin
            bit_cnt <= bit_cnt - 1'b1;
          end
        end
        S_PHY: begin
          phy_addr <= {phy_addr[ADDR_W-2:0], mdio_in};
          if (bit_cnt == '0) begin
            state   <= S_REG;
            bit_cnt <= BCW'(REG_W - 1);
          end else begin
            bit_cnt <= bit_cnt - 1'b1;
          end
        end
        S_REG: begin
          reg_addr <= {reg_addr[REG_W-2:0], mdio_in};
          if (bit_cnt == '0) state <= S_TA1;
          else               bit_cnt <= bit_cnt - 1'b1;
        end
        S_TA1: begin
          // Line stays free during the first turnaround bit; the zero
          // for the second bit goes out right after this edge.
          state   <= S_TA2;
          drv_oe  <= frame_rd && port_hit;
          drv_out <= 1'b0;
        end
        S_TA2: begin
          state   <= S_DATA;
          bit_cnt <= BCW'(DATA_W - 1);
          drv_out <= rd_word[DATA_W-1];
          rd_sh   <= {rd_word[DATA_W-2:0], 1'b0};
        end
        S_DATA: begin
          wd_sh <= wd_next;
          if (bit_cnt == '0) begin
            state   <= S_PRE;
            pre_cnt <= '0;
            drv_oe  <= 1'b0;
            if (!frame_rd && port_hit) begin
              wr_en   <= 1'b1;
              wr_data <= wd_next;
            end
          end else begin
            bit_cnt <= bit_cnt - 1'b1;
            drv_out <= rd_sh[DATA_W-1];
            rd_sh   <= {rd_sh[DATA_W-2:0], 1'b0};
          end
        end
        default: state <= S_PRE;
      endcase
    end
  end

endmodule

// File: rtl/mdio_mport_slave.sv
`timescale 1ns/1ps
module mdio_mport_slave #(
  parameter int NUM_PORTS = 8,
  parameter int NUM_REGS  = 32,
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 5,
  parameter int PRE_LEN   = 32,
  parameter int KEEP_BITS = 2,
  localparam int PIW      = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int REG_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              mdc,
  input  logic              rst_n,
  input  logic              mgmt_off,
  input  logic [ADDR_W-1:0] strap_base,
  input  logic              strap_reduced,
  input  logic              mdio_in,
  output logic              mdio_out,
  output logic              mdio_oe
);

  logic [ADDR_W-1:0] phy_addr;
  logic [REG_W-1:0]  reg_addr;
  logic              frame_rd;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_word;
  logic              port_hit;
  logic [PIW-1:0]    port_idx;
  logic              drv_oe;
  logic              drv_out;

  mdio_frame_dec #(
    .PRE_LEN(PRE_LEN), .ADDR_W(ADDR_W), .REG_W(REG_W), .DATA_W(DATA_W)
  ) u_dec (
    .mdc(mdc), .rst_n(rst_n), .mgmt_off(mgmt_off), .mdio_in(mdio_in),
    .port_hit(port_hit), .rd_word(rd_word),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .frame_rd(frame_rd),
    .wr_en(wr_en), .wr_data(wr_data), .drv_oe(drv_oe), .drv_out(drv_out)
  );

  mdio_port_match #(
    .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .KEEP_BITS(KEEP_BITS)
  ) u_match (
    .phy_addr(phy_addr), .strap_base(strap_base), .strap_reduced(strap_reduced),
    .port_hit(port_hit), .port_idx(port_idx)
  );

  mdio_reg_bank #(
    .NUM_PORTS(NUM_PORTS), .NUM_REGS(NUM_REGS), .DATA_W(DATA_W)
  ) u_bank (
    .mdc(mdc), .rst_n(rst_n),
    .wr_en(wr_en), .wr_port(port_idx), .wr_reg(reg_addr), .wr_data(wr_data),
    .rd_port(port_idx), .rd_reg(reg_addr), .rd_data(rd_word)
  );

  // The disable input overrides the registered enable at once.
  assign mdio_oe  = drv_oe && !mgmt_off;
  assign mdio_out = drv_out && mdio_oe;

endmodule

// File: rtl/mdio_mport_chk.sv
`timescale 1ns/1ps
module mdio_mport_chk (
  input logic mdc,
  input logic rst_n,
  input logic mgmt_off,
  input logic mdio_oe,
  input logic mdio_out,
  input logic port_hit,
  input logic frame_rd,
  input logic wr_en
);

  assert_off_silent_R9: assert property (@(posedge mdc) disable iff (!rst_n)
    mgmt_off |-> !mdio_oe);

  assert_ta_zero_R5: assert property (@(posedge mdc) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_out);

  assert_drive_only_hit_read_R8: assert property (@(posedge mdc) disable iff (!rst_n)
    mdio_oe |-> (port_hit && frame_rd));

  assert_write_only_hit_R8: assert property (@(posedge mdc) disable iff (!rst_n)
    wr_en |-> (port_hit && !frame_rd));

  assert_single_commit_R7: assert property (@(posedge mdc) disable iff (!rst_n)
    wr_en |=> !wr_en);

endmodule

bind mdio_mport_slave mdio_mport_chk u_chk (
  .mdc(mdc), .rst_n(rst_n), .mgmt_off(mgmt_off),
  .mdio_oe(mdio_oe), .mdio_out(mdio_out),
  .port_hit(port_hit), .frame_rd(frame_rd), .wr_en(wr_en)
);

// File: tb/sim_mdio_mport_slave.sv
`timescale 1ns/1ps
module sim_mdio_mport_slave;

  logic       mdc = 1'b0;
  logic       rst_n = 1'b0;
  logic       mgmt_off = 1'b0;
  logic [4:0] strap_base = 5'd5;
  logic       strap_reduced = 1'b0;
  logic       mdio_in = 1'b1;
  logic       mdio_out;
  logic       mdio_oe;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 mdc = ~mdc;  // 50 MHz

  mdio_mport_slave u0 (
    .mdc(mdc), .rst_n(rst_n), .mgmt_off(mgmt_off),
    .strap_base(strap_base), .strap_reduced(strap_reduced),
    .mdio_in(mdio_in), .mdio_out(mdio_out), .mdio_oe(mdio_oe)
  );

  // {is_wr, phy, reg, wdata, expect_reply, expect_data}; base 5, normal mode
  localparam logic [43:0] VEC [0:12] = '{
    {1'b1, 5'd5,  5'd3,  16'hA5A5, 1'b0, 16'h0000},  // R7 write port0
    {1'b0, 5'd5,  5'd3,  16'h0000, 1'b1, 16'hA5A5},  // R7 read back
    {1'b1, 5'd12, 5'd31, 16'h1234, 1'b0, 16'h0000},  // R3 top port, top reg
    {1'b0, 5'd12, 5'd31, 16'h0000, 1'b1, 16'h1234},
    {1'b0, 5'd6,  5'd3,  16'h0000, 1'b1, 16'h0000},  // R11 port1 untouched
    {1'b1, 5'd13, 5'd3,  16'hFFFF, 1'b0, 16'h0000},  // R8 just above range
    {1'b0, 5'd13, 5'd3,  16'h0000, 1'b0, 16'h0000},  // R8 no reply
    {1'b0, 5'd5,  5'd3,  16'h0000, 1'b1, 16'hA5A5},
    {1'b1, 5'd4,  5'd3,  16'hBEEF, 1'b0, 16'h0000},  // R8 just below base
    {1'b0, 5'd11, 5'd3,  16'h0000, 1'b1, 16'h0000},  // R11 port6
    {1'b1, 5'd6,  5'd3,  16'h8001, 1'b0, 16'h0000},
    {1'b0, 5'd6,  5'd3,  16'h0000, 1'b1, 16'h8001},
    {1'b0, 5'd5,  5'd3,  16'h0000, 1'b1, 16'hA5A5}   // R11 port0 kept
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // pre ones, then 32 frame slots, then 2 idle slots. Slot observations are
  // taken after the falling edge, i.e. the value the next rising edge sees.
  task automatic frame(input int pre, input logic [1:0] st, input logic [1:0] op,
                       input logic [4:0] phy, input logic [4:0] ra,
                       input logic [15:0] wd,
                       output logic ta1, output logic shape, output logic rel,
                       output logic anyoe, output logic [15:0] rd);
    logic [31:0] bits;
    if (op == 2'b10) bits = {st, op, phy, ra, 2'b11, 16'hFFFF};
    else             bits = {st, op, phy, ra, 2'b10, wd};
    anyoe = 1'b0; shape = 1'b1; ta1 = 1'b0; rel = 1'b1; rd = '0;
    for (int i = 0; i < pre; i++) begin
      @(negedge mdc); mdio_in = 1'b1; #1; anyoe |= mdio_oe;
    end
    for (int k = 0; k < 32; k++) begin
      @(negedge mdc); mdio_in = bits[31-k]; #1;
      anyoe |= mdio_oe;
      if (k == 14) ta1 = mdio_oe;
      if (k == 15) shape &= mdio_oe && !mdio_out;
      if (k >= 16) begin
        shape &= mdio_oe;
        rd[31-k] = mdio_out;
      end
    end
    for (int j = 0; j < 2; j++) begin
      @(negedge mdc); mdio_in = 1'b1; #1;
      rel &= !mdio_oe; anyoe |= mdio_oe;
    end
  endtask

  task automatic wr(input int pre, input logic [4:0] phy, input logic [4:0] ra,
                    input logic [15:0] d);
    logic a, b, c, e; logic [15:0] r;
    frame(pre, 2'b01, 2'b01, phy, ra, d, a, b, c, e, r);
    chk(!e, "R7 write frame must not drive", {31'd0, e}, 32'd0);
  endtask

  task automatic rd_expect(input logic [4:0] phy, input logic [4:0] ra,
                           input logic [15:0] exp, input string req);
    logic a, b, c, e; logic [15:0] r;
    frame(32, 2'b01, 2'b10, phy, ra, 16'h0, a, b, c, e, r);
    chk(!a && b && c, "R5/R6 turnaround and release", {29'd0, a, b, c}, 32'b011);
    chk(r == exp, req, {16'd0, r}, {16'd0, exp});
  endtask

  task automatic rd_silent(input logic [4:0] phy, input logic [4:0] ra,
                           input string req);
    logic a, b, c, e; logic [15:0] r;
    frame(32, 2'b01, 2'b10, phy, ra, 16'h0, a, b, c, e, r);
    chk(!e, req, {31'd0, e}, 32'd0);
  endtask

  initial begin : watchdog
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic a, b, c, e; logic [15:0] r;
    repeat (4) @(negedge mdc);
    chk(!mdio_oe, "R10 enable low in reset", {31'd0, mdio_oe}, 32'd0);
    rst_n = 1'b1;
    @(negedge mdc);
    chk(!mdio_oe, "R10 enable low after reset", {31'd0, mdio_oe}, 32'd0);
    rd_expect(5'd5, 5'd3, 16'h0000, "R10 register zero after reset");

    for (int i = 0; i < 13; i++) begin
      logic [43:0] v;
      v = VEC[i];
      if (v[43]) wr(32, v[42:38], v[37:33], v[32:17]);
      else if (v[16]) rd_expect(v[42:38], v[37:33], v[15:0], "R7/R11 read data");
      else rd_silent(v[42:38], v[37:33], "R8 unmatched address silent");
    end

    // R1: previous read leaves 2 idle ones counted; 29 more makes 31 (short).
    wr(29, 5'd5, 5'd3, 16'h0000);
    rd_expect(5'd5, 5'd3, 16'hA5A5, "R1 short preamble ignored");
    // previous read adds 2 idle ones; 30 more makes exactly 32
    wr(30, 5'd5, 5'd3, 16'h5A5A);
    rd_expect(5'd5, 5'd3, 16'h5A5A, "R1 exact preamble accepted");
    frame(32, 2'b00, 2'b01, 5'd5, 5'd3, 16'h0000, a, b, c, e, r);
    chk(!e, "R1 bad start silent", {31'd0, e}, 32'd0);
    rd_expect(5'd5, 5'd3, 16'h5A5A, "R1 bad start ignored");

    // R2: illegal opcodes
    frame(32, 2'b01, 2'b11, 5'd5, 5'd3, 16'h0000, a, b, c, e, r);
    chk(!e, "R2 opcode 11 silent", {31'd0, e}, 32'd0);
    frame(32, 2'b01, 2'b00, 5'd5, 5'd3, 16'h0000, a, b, c, e, r);
    chk(!e, "R2 opcode 00 silent", {31'd0, e}, 32'd0);
    rd_expect(5'd5, 5'd3, 16'h5A5A, "R2 illegal opcode no write");

    // R9: disabled slave
    mgmt_off = 1'b1;
    wr(32, 5'd5, 5'd3, 16'h0000);
    rd_silent(5'd5, 5'd3, "R9 disabled read silent");
    mgmt_off = 1'b0;
    rd_expect(5'd5, 5'd3, 16'h5A5A, "R9 disabled write ignored");

    // R4: reduced strap 10111 -> base 16
    strap_reduced = 1'b1; strap_base = 5'b10111;
    wr(32, 5'd18, 5'd1, 16'h1111);
    rd_expect(5'd18, 5'd1, 16'h1111, "R4 reduced base read");
    rd_silent(5'd24, 5'd1, "R4 reduced base range end");
    strap_reduced = 1'b0; strap_base = 5'd0;
    rd_expect(5'd2, 5'd1, 16'h1111, "R4 write landed in port2");

    // R3: wrap past 31 with base 30 (phy 1 = port 3)
    strap_base = 5'd30;
    wr(32, 5'd1, 5'd9, 16'h0F0F);
    rd_silent(5'd29, 5'd9, "R3 below wrapped base silent");
    strap_base = 5'd0;
    rd_expect(5'd3, 5'd9, 16'h0F0F, "R3 wrapped address maps to port3");

    // R10: reset clears stored values
    @(negedge mdc); rst_n = 1'b0;
    repeat (2) @(negedge mdc); rst_n = 1'b1;
    rd_expect(5'd3, 5'd9, 16'h0000, "R10 reset clears registers");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule